// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Controller

This block sits between a pulse-width modulator and the gate drivers of a synchronous buck stage. It turns a single PWM input into two registered gate enables, one for the high-side switch and one for the low-side switch. Neither enable is raised until the opposite switch has been seen off. The dead time therefore follows the actual switching speed of the power stage, not a fixed count. Three comparator flags report this: the switch node is low, the high-side gate is low, and the low-side gate is low. A cycle-count timeout acts as a fallback for low-side turn-on when the switch node never collapses, for example with a shorted high-side switch.

Four override inputs sit on top of the PWM path, in a fixed priority order. Crowbar is the strongest and forces the low-side switch on. Undervoltage lockout and shutdown turn both switches off. The low-side enable keeps only the synchronous rectifier off, which helps at light load.

Every control and flag input is synchronised before use. Both outputs come straight from flip-flops.

Top module: `deadtime_ctrl`

## Requirements
- R1: While reset is asserted both outputs are 0. After reset neither output rises until the sensing flags (or the timeout) allow it. With the PWM input low and no flag low, both stay 0.
- R2: Each input passes two synchronising flip-flops and the outputs are registered. A change applied before clock edge 1 can first alter an output at edge 3.
- R3: With the PWM input high (and no override), the low-side output drops first. The high-side output rises only in a cycle after the low-side output is 0 and the low-gate-low flag is 1. It then stays high while the PWM input stays high.
- R4: With the PWM input low (and no override), the high-side output drops first. The low-side output rises once the high-side output is 0 and both the switch-node-low and high-gate-low flags are 1.
- R5: On each falling PWM edge a timer of TMO_CYCLES cycles starts. If the flags have not allowed it earlier, the low-side output rises at edge TMO_CYCLES+4 counted from the input change.
- R6: A rising PWM input before expiry cancels the timer, and the pending low-side turn-on is dropped. The next falling edge restarts a full timeout.
- R7: Shutdown input low (active low) forces both outputs to 0.
- R8: Undervoltage-lockout input high forces both outputs to 0. After release, normal sequencing resumes.
- R9: Low-side enable input low holds the low-side output at 0 while the high-side output keeps following the PWM input.
- R10: Crowbar input high forces the high-side output to 0 and the low-side output to 1. It overrides shutdown, lockout, low-side enable and the dead-time logic.
- R11: The two outputs are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command, 1 = high side, 0 = low side |
| sd_n_i | input | 1 | Shutdown, active low |
| ls_en_i | input | 1 | Low-side enable, 0 keeps the low side off |
| crowbar_i | input | 1 | Overvoltage crowbar request, active high |
| uvlo_i | input | 1 | Supply undervoltage lockout, active high |
| sw_low_i | input | 1 | Switch node below threshold |
| hg_low_i | input | 1 | High-side gate below threshold |
| lg_low_i | input | 1 | Low-side gate below threshold |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |

## Verification
Two functions can collide in one cycle.

The first collision is between the timeout and a new PWM rise. The bench cancels a running timeout with a short high pulse and then falls again at a point where the old timer would still have expired. It checks that the low side stays off until the full new window ends. This separates a cancelled timer from a merely paused one.

The second collision is between the crowbar and the dead-time sequencer. The bench raises crowbar together with shutdown, lockout and low-side disable while the high side is on. It expects the low side on and the high side off in the same cycle. Random phases, where these overrides flicker against PWM edges, are compared every cycle against a bench model.

// File: rtl/deadtime_ctrl.sv
module deadtime_ctrl #(
  parameter int TMO_CYCLES  = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic sd_n_i,
  input  logic ls_en_i,
  input  logic crowbar_i,
  input  logic uvlo_i,
  input  logic sw_low_i,
  input  logic hg_low_i,
  input  logic lg_low_i,
  output logic hs_on_o,
  output logic ls_on_o
);
  localparam int NIN = 8;
  localparam int CW  = $clog2(TMO_CYCLES + 1) < 1 ? 1 : $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYCLES);

  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic cb, uv, sdn, lsen, pwm, swl, hgl, lgl;
  logic pwm_d, armed, tmo_hit, hs_nxt, ls_nxt;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {crowbar_i, uvlo_i, sd_n_i, ls_en_i, pwm_i, sw_low_i, hg_low_i, lg_low_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {cb, uv, sdn, lsen, pwm, swl, hgl, lgl} = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_d <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      pwm_d <= pwm;
      if (pwm) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (pwm_d) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && cnt != TMO_LAST) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign tmo_hit = armed && (cnt == TMO_LAST);

  always_comb begin
    hs_nxt = 1'b0;
    ls_nxt = 1'b0;
    if (cb) begin
      ls_nxt = 1'b1;
    end else if (!uv && sdn) begin
      if (pwm) hs_nxt = hs_on_o | (lgl & ~ls_on_o);
      else     ls_nxt = lsen & (ls_on_o | (~hs_on_o & ((swl & hgl) | tmo_hit)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_on_o <= 1'b0;
      ls_on_o <= 1'b0;
    end else begin
      hs_on_o <= hs_nxt;
      ls_on_o <= ls_nxt;
    end
  end

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on_o && ls_on_o));

  // R10
  crowbar_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cb |=> (ls_on_o && !hs_on_o));

  // R7 R8
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cb && (uv || !sdn)) |=> (!hs_on_o && !ls_on_o));

  // R9
  ls_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cb && !lsen) |=> !ls_on_o);

  // R3
  hs_after_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on_o) |-> $past(!ls_on_o && lgl && pwm));

  // R4 R5
  ls_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_on_o) && !$past(cb)) |-> $past(!hs_on_o && !pwm && ((swl && hgl) || tmo_hit)));

  // R6
  tmo_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm |=> !tmo_hit);
endmodule

// File: tb/deadtime_ctrl_tb_top.sv
module deadtime_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 0, sd_n = 1, ls_en = 1, crowbar = 0, uvlo = 0;
  logic sw_low = 0, hg_low = 0, lg_low = 0;
  logic hs_on, ls_on;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deadtime_ctrl #(.TMO_CYCLES(TMO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .sd_n_i(sd_n), .ls_en_i(ls_en),
    .crowbar_i(crowbar), .uvlo_i(uvlo), .sw_low_i(sw_low), .hg_low_i(hg_low),
    .lg_low_i(lg_low), .hs_on_o(hs_on), .ls_on_o(ls_on));

  // bench reference model built from the requirements
  logic [7:0] m_s1, m_s2;
  logic m_hs, m_ls, m_pd, m_armed;
  int   m_cnt;

  function automatic logic [1:0] ref_next(logic [7:0] s, logic hs, logic ls, logic hit);
    logic c, u, d, e, p, w, h, g;
    {c, u, d, e, p, w, h, g} = s;
    if (c) return 2'b01;
    if (u || !d) return 2'b00;
    if (p) return {hs | (g & ~ls), 1'b0};
    return {1'b0, e & (ls | (~hs & ((w & h) | hit)))};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_hs = 0; m_ls = 0; m_pd = 0; m_armed = 0; m_cnt = 0;
    end else begin
      logic [1:0] nx;
      nx = ref_next(m_s2, m_hs, m_ls, m_armed && m_cnt == TMO);
      if (m_s2[3]) begin m_armed = 0; m_cnt = 0; end
      else if (m_pd) begin m_armed = 1; m_cnt = 0; end
      else if (m_armed && m_cnt != TMO) m_cnt++;
      m_pd = m_s2[3];
      {m_hs, m_ls} = nx;
      m_s2 = m_s1;
      m_s1 = {crowbar, uvlo, sd_n, ls_en, pwm, sw_low, hg_low, lg_low};
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_now();
    if (crowbar) return "R10";
    if (uvlo) return "R8";
    if (!sd_n) return "R7";
    if (!ls_en) return "R9";
    return "R4";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    int run;
    bit stuck;
    void'($urandom(32'd20240611));
    waitn(3);
    chk("R1", "hs in reset", hs_on, 0);
    chk("R1", "ls in reset", ls_on, 0);
    rst_n = 1;
    waitn(10);
    chk("R1", "hs idle", hs_on, 0);
    chk("R1", "ls idle without flags", ls_on, 0);

    sw_low = 1; hg_low = 1;
    waitn(2);
    chk("R2", "ls before sync", ls_on, 0);
    waitn(1);
    chk("R4", "ls on at edge 3", ls_on, 1);

    pwm = 1;
    waitn(3);
    chk("R3", "ls dropped", ls_on, 0);
    chk("R3", "hs waits lg flag", hs_on, 0);
    waitn(5);
    chk("R3", "hs still waits", hs_on, 0);
    lg_low = 1;
    waitn(3);
    chk("R3", "hs on after lg flag", hs_on, 1);

    sw_low = 0; hg_low = 0; pwm = 0;
    waitn(3);
    chk("R4", "hs dropped", hs_on, 0);
    waitn(TMO);
    chk("R5", "ls before timeout", ls_on, 0);
    waitn(1);
    chk("R5", "ls at timeout", ls_on, 1);

    pwm = 1;
    waitn(4);
    chk("R3", "hs on again", hs_on, 1);
    pwm = 0;
    waitn(12);
    pwm = 1;
    waitn(4);
    pwm = 0;
    bad = 0;
    for (int i = 0; i < TMO + 3; i++) begin
      waitn(1);
      if (ls_on) bad++;
    end
    chk("R6", "ls held after cancel", bad != 0, 0);
    waitn(1);
    chk("R6", "ls at restarted timeout", ls_on, 1);

    pwm = 1;
    waitn(6);
    chk("R3", "hs on before sd", hs_on, 1);
    sd_n = 0;
    waitn(3);
    chk("R7", "hs off in sd", hs_on, 0);
    chk("R7", "ls off in sd", ls_on, 0);
    sd_n = 1;
    waitn(3);
    chk("R7", "hs back after sd", hs_on, 1);

    uvlo = 1;
    waitn(3);
    chk("R8", "hs off in lockout", hs_on, 0);
    pwm = 0; sw_low = 1; hg_low = 1;
    waitn(6);
    chk("R8", "ls off in lockout", ls_on, 0);
    uvlo = 0;
    waitn(3);
    chk("R8", "ls after release", ls_on, 1);

    ls_en = 0;
    waitn(3);
    chk("R9", "ls disabled", ls_on, 0);
    pwm = 1;
    waitn(3);
    chk("R9", "hs follows pwm", hs_on, 1);
    pwm = 0;
    waitn(6);
    chk("R9", "hs off", hs_on, 0);
    chk("R9", "ls still disabled", ls_on, 0);
    ls_en = 1;
    waitn(3);
    chk("R9", "ls after enable", ls_on, 1);

    pwm = 1;
    waitn(4);
    chk("R3", "hs on before crowbar", hs_on, 1);
    crowbar = 1; sd_n = 0; uvlo = 1; ls_en = 0;
    waitn(3);
    chk("R10", "hs forced off", hs_on, 0);
    chk("R10", "ls forced on", ls_on, 1);
    crowbar = 0; sd_n = 1; uvlo = 0; ls_en = 1;
    waitn(3);
    chk("R3", "ls dropped after crowbar", ls_on, 0);
    chk("R3", "hs not yet", hs_on, 0);
    waitn(1);
    chk("R3", "hs after crowbar", hs_on, 1);

    run = 0;
    stuck = 0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      chk(tag_now(), "model hs", hs_on, m_hs);
      chk(tag_now(), "model ls", ls_on, m_ls);
      chk("R11", "overlap", hs_on & ls_on, 0);
      if (run == 0) begin
        pwm = ~pwm;
        run = 4 + int'($urandom % 40);
        stuck = ($urandom % 3) == 0;
      end else run--;
      sw_low = stuck ? 1'b0 : 1'($urandom % 2);
      hg_low = 1'($urandom % 2);
      lg_low = ($urandom % 4) != 0;
      crowbar = ($urandom % 100) < 2;
      uvlo = ($urandom % 100) < 3;
      sd_n = ($urandom % 100) >= 3;
      ls_en = ($urandom % 100) >= 10;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule